// File: doc/BRIEF.md
# Policy-Configurable Message Queue

This block carries messages from one writer to one reader. Both sides use the same clock. Each side has a valid/ready handshake. The queue runs in one of two modes:

- **Buffered mode** keeps messages in a circular store whose depth is a power of two.
- **Rendezvous mode** has no storage. A message moves only in a cycle where the writer offers it and the reader accepts it.

Two policy inputs say what happens when a side cannot proceed. One covers a writer facing a full store, the other a reader facing no data. The writer can wait, replace the oldest stored entry, or give up after a programmed number of cycles. The reader can wait, receive the last message it was given (marked stale), or give up after a programmed number of cycles.

A timed-out request still completes its handshake. The matching timeout output pulses in that cycle so the requester knows the request failed. A write that times out is discarded. A read that times out returns zero. Status outputs give the fill level, full and empty, and a sticky flag that records any overwrite. The mode input is meant to stay fixed while traffic flows.

Top module: `policy_msg_queue`

## Requirements
- R1: A synchronous active-high reset empties the queue and clears the overwrite flag and the remembered last message.
  - After reset `level` is 0, `empty` is 1 and `full` is 0.
  - A stale read then returns zero.
- R2: In buffered mode, messages leave in the order they were accepted.
  - `level` counts stored entries.
  - `full` rises at DEPTH entries.
  - `wr_ready` is high whenever the store is not full.
- R3: With `full_mode` = 0 (block) or 3, a write to a full store is held off (`wr_ready` low) until a read frees space.
- R4: With `full_mode` = 1 (overwrite), a write to a full store is accepted and the oldest entry is discarded.
  - `level` stays at DEPTH.
  - `overflow` sets and stays set until reset.
- R5: A write and a read in the same cycle on a full store are both accepted. Nothing is discarded and `overflow` is unchanged.
- R6: A message written into an empty store is not offered to the reader in the same cycle. It is offered from the next cycle on.
- R7: With `empty_mode` = 1 (previous), a reader facing no data gets `rd_valid` high, `rd_stale` high and the last delivered message.
  - The queue state is left unchanged.
  - Before any delivery since reset, the returned value is zero.
- R8: With `full_mode` = 2 (timeout) and limit L in `wr_limit`, a blocked write is handled in its (L+1)-th consecutive waiting cycle:
  - `wr_ready` goes high and `wr_timeout` pulses in that cycle.
  - The message is discarded.
- R9: With `empty_mode` = 2 (timeout) and limit L in `rd_limit`, a blocked read is handled in its (L+1)-th consecutive waiting cycle:
  - `rd_valid` and `rd_timeout` go high in that cycle.
  - `rd_data` is zero.
- R10: With `buffered` = 0, `rd_valid` and `rd_data` follow `wr_valid` and `wr_data`, and `wr_ready` follows `rd_ready`.
  - `level` stays unchanged.
  - Overwrite (`full_mode` = 1) acts as block in this mode.
- R11: In rendezvous mode, the previous and timeout policies of R7, R8 and R9 apply to whichever side is left waiting.
  - The remembered message is the last one that crossed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buffered | input | 1 | 1 = buffered mode, 0 = rendezvous mode |
| full_mode | input | 2 | Write-on-full policy: 0 block, 1 overwrite, 2 timeout, 3 block |
| empty_mode | input | 2 | Read-on-empty policy: 0 block, 1 previous, 2 timeout, 3 block |
| wr_limit | input | TW | Writer timeout limit in cycles |
| rd_limit | input | TW | Reader timeout limit in cycles |
| wr_valid | input | 1 | Writer offers a message |
| wr_data | input | DW | Writer message |
| wr_ready | output | 1 | Write handshake completes this cycle |
| rd_valid | output | 1 | Read handshake can complete this cycle |
| rd_data | output | DW | Message offered to the reader |
| rd_ready | input | 1 | Reader wants a message |
| rd_stale | output | 1 | Offered message is the previous one |
| level | output | $clog2(DEPTH)+1 | Stored entry count |
| full | output | 1 | Store holds DEPTH entries |
| empty | output | 1 | Store holds no entries |
| overflow | output | 1 | Sticky: an overwrite has discarded an entry |
| wr_timeout | output | 1 | Writer request dropped by timeout this cycle |
| rd_timeout | output | 1 | Reader request ended by timeout this cycle |

## Verification
A corrupted read or write pointer shows up at the reader's data port as an out-of-order or repeated message. It appears at the first delivery that reaches the wrong slot, which the scoreboard catches at once.

A miscounted fill level shows up on `level`, `full` and `wr_ready` within one cycle. It also surfaces when a drain delivers more or fewer messages than were accepted.

A timeout counter that is off by one moves the timeout pulse one cycle earlier or later than the programmed limit allows. The remembered last message is checked on every stale read, including right after reset, where it must be zero.

// File: rtl/policy_msg_queue.sv
module policy_msg_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int TW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   buffered,
  input  logic [1:0]             full_mode,
  input  logic [1:0]             empty_mode,
  input  logic [TW-1:0]          wr_limit,
  input  logic [TW-1:0]          rd_limit,
  input  logic                   wr_valid,
  input  logic [DW-1:0]          wr_data,
  output logic                   wr_ready,
  output logic                   rd_valid,
  output logic [DW-1:0]          rd_data,
  input  logic                   rd_ready,
  output logic                   rd_stale,
  output logic [$clog2(DEPTH):0] level,
  output logic                   full,
  output logic                   empty,
  output logic                   overflow,
  output logic                   wr_timeout,
  output logic                   rd_timeout
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);
  localparam logic [1:0] P_ALT = 2'd1;
  localparam logic [1:0] P_TMO = 2'd2;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [AW:0]   cnt;
  logic [DW-1:0] last;
  logic          ovf;
  logic [TW-1:0] wwait, rwait;

  logic avail, space, ovr_ok, stale, wr_to, rd_to;
  logic push, pop, drop, meet;

  assign full  = cnt == FULLV;
  assign empty = cnt == '0;
  assign level = cnt;
  assign overflow = ovf;

  assign avail  = buffered ? !empty : wr_valid;
  assign space  = buffered ? (!full || rd_ready) : rd_ready;
  assign ovr_ok = buffered && full_mode == P_ALT;
  assign stale  = empty_mode == P_ALT && !avail;
  assign wr_to  = full_mode == P_TMO && wr_valid && !space && wwait == wr_limit;
  assign rd_to  = empty_mode == P_TMO && rd_ready && !avail && rwait == rd_limit;

  assign wr_ready   = space || ovr_ok || wr_to;
  assign rd_valid   = avail || stale || rd_to;
  assign rd_stale   = stale;
  assign wr_timeout = wr_to;
  assign rd_timeout = rd_to;
  assign rd_data    = avail ? (buffered ? mem[rp] : wr_data) : (stale ? last : '0);

  assign push = buffered && wr_valid && (space || ovr_ok);
  assign pop  = buffered && rd_ready && !empty;
  assign drop = push && full && !pop;
  assign meet = !buffered && wr_valid && rd_ready;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp    <= '0;
      wp    <= '0;
      cnt   <= '0;
      last  <= '0;
      ovf   <= 1'b0;
      wwait <= '0;
      rwait <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop || drop) rp <= rp + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, push && !drop} - {{AW{1'b0}}, pop};
      if (drop) ovf <= 1'b1;
      if (pop) last <= mem[rp];
      else if (meet) last <= wr_data;
      wwait <= (full_mode == P_TMO && wr_valid && !space && !wr_to) ? wwait + 1'b1 : '0;
      rwait <= (empty_mode == P_TMO && rd_ready && !avail && !rd_to) ? rwait + 1'b1 : '0;
    end
  end
endmodule

module policy_msg_queue_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   buffered,
  input logic [1:0]             full_mode,
  input logic [1:0]             empty_mode,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic                   rd_valid,
  input logic [DW-1:0]          rd_data,
  input logic                   rd_ready,
  input logic                   rd_stale,
  input logic [$clog2(DEPTH):0] level,
  input logic                   full,
  input logic                   empty,
  input logic                   overflow,
  input logic                   wr_timeout,
  input logic                   rd_timeout
);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH);
  p_block_on_full_r3: assert property (@(posedge clk) disable iff (rst)
    buffered && full && (full_mode == 2'd0 || full_mode == 2'd3) && !rd_ready |-> !wr_ready);
  p_overwrite_keeps_full_r4: assert property (@(posedge clk) disable iff (rst)
    buffered && full && full_mode == 2'd1 && wr_valid && !rd_ready |=> full && overflow);
  p_overflow_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  p_full_rw_both_r5: assert property (@(posedge clk) disable iff (rst)
    buffered && full && wr_valid && rd_ready |=> full && $stable(overflow));
  p_no_passthru_r6: assert property (@(posedge clk) disable iff (rst)
    buffered && empty && (empty_mode == 2'd0 || empty_mode == 2'd3) |-> !rd_valid);
  p_stale_only_idle_r7: assert property (@(posedge clk) disable iff (rst)
    rd_stale |-> rd_valid && (buffered ? empty : !wr_valid));
  p_wr_timeout_hs_r8: assert property (@(posedge clk) disable iff (rst)
    wr_timeout |-> wr_valid && wr_ready && !full_mode[0]);
  p_rd_timeout_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_timeout |-> rd_valid && rd_data == '0 && !rd_stale);
  p_rendezvous_wait_r10: assert property (@(posedge clk) disable iff (rst)
    !buffered && wr_valid && !rd_ready && full_mode != 2'd2 |-> !wr_ready);
endmodule

bind policy_msg_queue policy_msg_queue_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_policy_msg_queue.sv
module tb_policy_msg_queue;
  localparam int DW = 8, DEPTH = 4, TW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, buffered = 1'b1;
  logic [1:0] full_mode = 2'd0, empty_mode = 2'd0;
  logic [TW-1:0] wr_limit = '0, rd_limit = '0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, rd_stale, full, empty, overflow, wr_timeout, rd_timeout;
  logic [DW-1:0] rd_data;
  logic [$clog2(DEPTH):0] level;

  policy_msg_queue #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit ended = 0;
  logic [DW-1:0] sb[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic tick(bit wv, logic [DW-1:0] wd, bit rr, bit expect_item);
    @(negedge clk);
    wr_valid = wv; wr_data = wd; rd_ready = rr;
    if (expect_item) sb.push_back(wd);
    #8;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  always begin
    logic [DW-1:0] e;
    @(negedge clk); #8;
    if (!rst && rd_valid && rd_ready && !rd_stale && !rd_timeout) begin
      if (sb.size() == 0) chk(0, "R2 unexpected delivery", rd_data, 0);
      else begin
        e = sb.pop_front();
        chk(rd_data == e, "R2 delivery order", rd_data, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    tick(0, 0, 0, 0);
    chk(level == 0 && empty && !full && !overflow, "R1 reset state", level, 0);
    chk(!rd_valid && wr_ready, "R1 reset handshake", rd_valid, 0);
    settle(); empty_mode = 2'd1;
    tick(0, 0, 1, 0);
    chk(rd_valid && rd_stale && rd_data == 0, "R1 cleared previous", rd_data, 0);

    settle(); empty_mode = 2'd0;
    tick(1, 8'h11, 1, 1);
    chk(!rd_valid, "R6 no same-cycle passthrough", rd_valid, 0);
    tick(1, 8'h12, 0, 1);
    tick(1, 8'h13, 0, 1);
    tick(1, 8'h14, 0, 1);
    tick(0, 0, 0, 0);
    chk(level == 4 && full, "R2 full at depth", level, 4);

    for (int i = 0; i < 3; i++) begin
      tick(1, 8'hAA, 0, 0);
      chk(!wr_ready, "R3 blocked on full", wr_ready, 0);
    end
    tick(1, 8'h15, 1, 1);
    chk(wr_ready && rd_valid, "R5 simultaneous read/write on full", wr_ready, 1);
    tick(0, 0, 0, 0);
    chk(level == 4 && !overflow, "R5 level kept, no overflow", level, 4);

    settle(); full_mode = 2'd1;
    tick(1, 8'h16, 0, 0);
    chk(wr_ready && !wr_timeout, "R4 overwrite accepted", wr_ready, 1);
    void'(sb.pop_front()); sb.push_back(8'h16);
    tick(0, 0, 0, 0);
    chk(level == 4 && overflow, "R4 level full and overflow set", level, 4);
    for (int i = 0; i < 4; i++) tick(0, 0, 1, 0);
    tick(0, 0, 0, 0);
    chk(level == 0 && empty && sb.size() == 0, "R2 drained", level, 0);
    chk(overflow, "R4 overflow sticky", overflow, 1);

    settle(); empty_mode = 2'd1;
    tick(0, 0, 1, 0);
    chk(rd_valid && rd_stale && rd_data == 8'h16, "R7 previous message", rd_data, 8'h16);
    tick(0, 0, 0, 0);
    chk(level == 0, "R7 no state change", level, 0);

    settle(); empty_mode = 2'd2; rd_limit = 8'd3;
    for (int i = 0; i < 5; i++) begin
      tick(0, 0, 1, 0);
      chk(rd_timeout == (i == 3) && rd_valid == (i == 3), "R9 read timeout cycle", rd_timeout, i == 3);
      if (i == 3) chk(rd_data == 0, "R9 timeout data zero", rd_data, 0);
    end

    settle(); empty_mode = 2'd0; full_mode = 2'd0;
    tick(1, 8'h21, 0, 1);
    tick(1, 8'h22, 0, 1);
    tick(1, 8'h23, 0, 1);
    tick(1, 8'h24, 0, 1);
    settle(); full_mode = 2'd2; wr_limit = 8'd2;
    for (int i = 0; i < 3; i++) begin
      tick(1, 8'h99, 0, 0);
      chk(wr_ready == (i == 2) && wr_timeout == (i == 2), "R8 write timeout cycle", wr_timeout, i == 2);
    end
    tick(0, 0, 0, 0);
    chk(level == 4, "R8 timed-out write discarded", level, 4);
    for (int i = 0; i < 4; i++) tick(0, 0, 1, 0);
    tick(0, 0, 0, 0);
    chk(sb.size() == 0 && empty, "R8 drain after timeout", sb.size(), 0);

    settle(); buffered = 1'b0; full_mode = 2'd0; empty_mode = 2'd0;
    tick(1, 8'h31, 0, 0);
    chk(!wr_ready && rd_valid && rd_data == 8'h31, "R10 writer waits for reader", wr_ready, 0);
    tick(1, 8'h31, 1, 1);
    chk(wr_ready && rd_valid, "R10 rendezvous transfer", wr_ready, 1);
    tick(0, 0, 1, 0);
    chk(!rd_valid, "R10 reader waits for writer", rd_valid, 0);
    settle(); full_mode = 2'd1;
    tick(1, 8'h32, 0, 0);
    chk(!wr_ready, "R10 overwrite acts as block", wr_ready, 0);
    tick(0, 0, 0, 0);
    chk(level == 0, "R10 level unchanged", level, 0);

    settle(); empty_mode = 2'd1;
    tick(0, 0, 1, 0);
    chk(rd_valid && rd_stale && rd_data == 8'h31, "R11 previous in rendezvous", rd_data, 8'h31);
    settle(); empty_mode = 2'd2; rd_limit = 8'd1;
    for (int i = 0; i < 2; i++) begin
      tick(0, 0, 1, 0);
      chk(rd_timeout == (i == 1), "R11 read timeout in rendezvous", rd_timeout, i == 1);
    end
    settle(); full_mode = 2'd2; wr_limit = 8'd0;
    tick(1, 8'h55, 0, 0);
    chk(wr_ready && wr_timeout, "R11 write timeout in rendezvous", wr_timeout, 1);

    settle(); rst = 1'b1;
    tick(0, 0, 0, 0);
    settle(); rst = 1'b0; buffered = 1'b1; full_mode = 2'd0; empty_mode = 2'd1;
    tick(0, 0, 1, 0);
    chk(rd_stale && rd_data == 0 && !overflow && level == 0, "R1 reset clears flags and previous", rd_data, 0);

    tick(0, 0, 0, 0);
    report();
  end
endmodule